// File: doc/BRIEF.md
# Enable-Gated Half-Rate Serial Receiver

This block is a receive-only serial port for short control words sent by a timing processor. Its interface is a master clock that never stops, a transfer enable that is active low and rests high, and one serial data line. While the enable is low, the block divides the master clock by two to make a bit clock. Data is sampled on each rising edge of that bit clock. After seven bits, the word is presented on a parallel output together with a one-cycle valid strobe.

All logic runs on the master clock, in one clock domain. The bit clock is a registered toggle. A single-cycle "take" enable marks each rising edge of the bit clock, so no derived clock drives any flop. When the enable is released, the block returns to idle. If the release comes part way through a word, the partial word is discarded and a framing-error pulse is raised. If the enable is held low past the end of a word, the next word starts without a gap.

Top module: `halfrate_serial_rx`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `rx_word` is 0 and `rx_valid`, `frame_err` and `bit_clk` are all 0.
- R2: The first master-clock rising edge that finds `ten_n` low samples `sdata` as the first bit. The next bits are sampled on every second edge after it, as long as `ten_n` stays low.
- R3: The first bit received lands in `rx_word[6]` and the seventh in `rx_word[0]` (MSB first).
- R4: `rx_word` and `rx_valid`=1 are presented at the edge that samples the seventh bit. `rx_valid` is high for exactly one cycle. `rx_word` keeps its value until the next complete word.
- R5: `sdata` values present on edges that are not sampling edges have no effect on `rx_word`.
- R6: `bit_clk` is 0 while `ten_n` is high. It becomes 1 at the first enabled edge, and it inverts on every edge while `ten_n` stays low.
- R7: If `ten_n` stays low for one more cycle after the seventh bit and is then released, no error is raised and no further valid is produced.
- R8: If `ten_n` is still low on the edge after that extra cycle, a new word begins, and that edge samples its first bit.
- R9: If `ten_n` is released after 1 to 6 bits have been sampled, `frame_err` pulses for one cycle. In that case `rx_valid` stays 0 and `rx_word` is unchanged.
- R10: After an aborted word, the next assertion of `ten_n` starts a fresh word, and its first bit lands in `rx_word[6]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, free running |
| rst_n | input | 1 | Synchronous reset, active low |
| ten_n | input | 1 | Transfer enable, active low |
| sdata | input | 1 | Serial data line |
| rx_word | output | 7 | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe for a new word |
| frame_err | output | 1 | One-cycle pulse when a word is aborted |
| bit_clk | output | 1 | Registered half-rate bit clock |

## Verification
Each result is one register stage after the edge that causes it. `bit_clk` updates at the very edge that samples `ten_n`. The word and `rx_valid` appear right after the edge that takes the seventh bit, which is the thirteenth enabled edge. `frame_err` appears right after the first edge that sees `ten_n` high. The bench changes inputs on falling edges and reads outputs a quarter period after each rising edge, so every check sees the state left by exactly one edge. On the edges between sampling edges it drives the inverted data bit, which exposes any sampling on the wrong phase.

// File: rtl/halfrate_serial_rx.sv
module halfrate_serial_rx #(
  parameter int WORD_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ten_n,
  input  logic              sdata,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              frame_err,
  output logic              bit_clk
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] sh_next;
  logic              en;
  logic              take;

  assign en      = ~ten_n;
  assign take    = en & ~bit_clk;
  assign sh_next = {shreg[WORD_W-2:0], sdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_clk   <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      rx_word   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      if (!en) begin
        bit_clk <= 1'b0;
        cnt     <= '0;
        if (cnt != '0) frame_err <= 1'b1;
      end else begin
        bit_clk <= ~bit_clk;
        if (take) begin
          shreg <= sh_next;
          if (cnt == LAST) begin
            rx_word  <= sh_next;
            rx_valid <= 1'b1;
            cnt      <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_word));
  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  p_err_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_err && rx_valid));
  p_bclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ten_n |=> !bit_clk);
  p_bclk_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ten_n |=> (bit_clk != $past(bit_clk)));
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(WORD_W));
endmodule

// File: tb/halfrate_serial_rx_test.sv
module halfrate_serial_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ten_n = 1'b1;
  logic       sdata = 1'b0;
  logic [6:0] rx_word;
  logic       rx_valid, frame_err, bit_clk;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  halfrate_serial_rx uut (
    .clk(clk), .rst_n(rst_n), .ten_n(ten_n), .sdata(sdata),
    .rx_word(rx_word), .rx_valid(rx_valid), .frame_err(frame_err), .bit_clk(bit_clk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic t, input logic d);
    @(negedge clk);
    ten_n = t;
    sdata = d;
    @(posedge clk);
    #5;
  endtask

  task automatic run_frame(input logic [6:0] w, input bit release_after);
    for (int i = 0; i < 7; i++) begin
      tick(1'b0, w[6-i]);
      chk("R6 bclk high on take", bit_clk, 1);
      if (i < 6) begin
        chk("R4 no early valid", rx_valid, 0);
        tick(1'b0, ~w[6-i]);
        chk("R6 bclk low between", bit_clk, 0);
      end
    end
    chk("R4 valid on 7th bit", rx_valid, 1);
    chk("R3 R5 word value", rx_word, w);
    chk("R2 no err", frame_err, 0);
    tick(1'b0, ~w[0]);
    chk("R4 valid one cycle", rx_valid, 0);
    if (release_after) begin
      tick(1'b1, 1'b0);
      chk("R7 no err on clean end", frame_err, 0);
      chk("R7 no valid", rx_valid, 0);
      chk("R7 word held", rx_word, w);
      chk("R6 bclk idle", bit_clk, 0);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #5;
    chk("R1 word reset", rx_word, 0);
    chk("R1 valid reset", rx_valid, 0);
    chk("R1 err reset", frame_err, 0);
    chk("R1 bclk reset", bit_clk, 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick(1'b1, 1'b1);
    chk("R1 idle after reset", {rx_valid, frame_err, bit_clk}, 0);
  endtask

  task automatic t_basic;
    run_frame(7'b1011001, 1'b1);
    tick(1'b1, 1'b0);
    run_frame(7'b0100110, 1'b1);
  endtask

  task automatic t_back_to_back;
    run_frame(7'b1110001, 1'b0);
    run_frame(7'b0001111, 1'b1);
    chk("R8 second word", rx_word, 7'b0001111);
  endtask

  task automatic t_abort;
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    tick(1'b1, 1'b0);
    chk("R9 err pulse", frame_err, 1);
    chk("R9 no valid", rx_valid, 0);
    chk("R9 word unchanged", rx_word, 7'b0001111);
    chk("R6 bclk idle after abort", bit_clk, 0);
    tick(1'b1, 1'b0);
    chk("R9 err one cycle", frame_err, 0);
    run_frame(7'b1000000, 1'b1);
    chk("R10 fresh word MSB", rx_word, 7'b1000000);
  endtask

  task automatic t_single_bit_abort;
    tick(1'b0, 1'b1);
    tick(1'b1, 1'b1);
    chk("R9 err after one bit", frame_err, 1);
    chk("R9 word kept", rx_word, 7'b1000000);
    tick(1'b1, 1'b0);
    run_frame(7'b0000001, 1'b1);
    chk("R10 word after short abort", rx_word, 7'b0000001);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_basic();
        t_back_to_back();
        t_abort();
        t_single_bit_abort();
      end
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule